// File: doc/BRIEF.md
# Four-Strike Watchdog with Companion Interval Timer

This block is a memory-mapped watchdog fed by its own interval timer. The timer divides a fixed one-microsecond tick by a programmable reload value. Each time the reload count elapses, it hands the watchdog one beat. The watchdog counts those beats down from a programmed period. Each time the countdown empties, it records a strike, reloads the period and may raise a one-cycle interrupt. On the fourth strike it stops and, if allowed, raises a system reset request. That request stays high until the block itself is reset.

Software keeps the system alive by writing the start command again before the fourth strike. The restart reloads the countdown and clears the strike count. Stopping the watchdog is guarded. A halt command only takes effect when the write just before it put a fixed key into the key register. A status register shows whether the watchdog is running, the current count and the strike count. From these, software can work out the time left as ((3 − strikes) × period + count) timer intervals.

Registers sit on word addresses of a byte-addressed 32-bit bus: 0x00 timer control, 0x04 watchdog setup, 0x08 status (read only), 0x0C command (write only, reads zero) and 0x10 key (write only, reads zero).

Top module: `expwd_unit`

## Requirements
- R1: After reset, the timer control, setup and status registers read zero, and neither the reset request nor the interrupt is asserted.
- R2: Timer control (0x00) holds the reload value in bits [28:0], periodic mode in bit 30 and enable in bit 31. A reload of 0 counts as 1. When enabled, the timer gives one beat each time reload ticks have been counted. In periodic mode it restarts and keeps going. Otherwise it stops after one beat. Writing zero stops it.
- R3: Setup (0x04) holds the timer select in bits [3:0], the period in bits [11:4], the interrupt enable in bit 12 and the reset enable in bit 15, and reads back those fields. Beats are counted only when the timer select equals 5. A period of 0 counts as 1.
- R4: Writing command bit 0 (0x0C) starts or restarts the watchdog. It sets status bit 0 (running), loads the count with the period and clears the strike count.
- R5: Status (0x08) shows the count in bits [11:4] and the strike count in bits [13:12]. Each counted beat lowers the count by one. A beat that finds the count at 1 with fewer than three strikes adds a strike and reloads the period. It also pulses the interrupt for one cycle when the interrupt enable is set.
- R6: A beat that finds the count at 1 with three strikes already recorded is the fourth strike. The count goes to 0, the running bit clears, no interrupt is given, and the reset request rises if the reset enable is set. The request stays high through restarts until reset.
- R7: Writing command bit 1 stops the watchdog only if the bus write just before it put 0x0000C45A into the key register (0x10). Otherwise the halt has no effect.
- R8: Each key write serves one halt only. Any other write, including a key write of another value, drops it.
- R9: If a restart command and an expiring beat reach the watchdog in the same cycle, the restart wins: the count reloads, the strike count is 0 and no interrupt is given.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low reset, clears all state |
| tick_1us_i | input | 1 | One-cycle pulse per microsecond from the fixed time base |
| bus_wr_i | input | 1 | Write strobe |
| bus_waddr_i | input | 5 | Write byte address |
| bus_wdata_i | input | 32 | Write data |
| bus_raddr_i | input | 5 | Read byte address |
| bus_rdata_o | output | 32 | Read data, combinational from the read address |
| wdt_irq_o | output | 1 | One-cycle pulse per non-final strike when enabled |
| sys_rst_req_o | output | 1 | Sticky system reset request |

## Verification
Two actions can reach the watchdog's counter in the same clock cycle: a software restart and a timer beat that would empty the countdown. The bench sets this up by bringing the count to 1. It then drives the microsecond tick one cycle before the restart write, so the registered beat and the command arrive at the same edge. The result is judged from the status register and the interrupt: the count must equal the period, the strike count must be zero and no interrupt may appear.

// File: rtl/expwd_pkg.sv
`timescale 1ns/1ps
package expwd_pkg;
   localparam int REG_TMR  = 0;
   localparam int REG_CFG  = 1;
   localparam int REG_STAT = 2;
   localparam int REG_CMD  = 3;
   localparam int REG_KEY  = 4;

   localparam int CFG_SEL_LSB = 0;
   localparam int CFG_PER_LSB = 4;
   localparam int CFG_IRQ_BIT = 12;
   localparam int CFG_RST_BIT = 15;

   localparam int ST_RUN_BIT = 0;
   localparam int ST_CNT_LSB = 4;
   localparam int ST_EXP_LSB = 12;

   localparam int CMD_GO_BIT   = 0;
   localparam int CMD_HALT_BIT = 1;

   localparam int TMR_EN_BIT  = 31;
   localparam int TMR_PER_BIT = 30;

   localparam logic [31:0] HALT_KEY = 32'h0000_C45A;
endpackage

// File: rtl/expwd_timer.sv
`timescale 1ns/1ps
module expwd_timer
   import expwd_pkg::*;
#(
   parameter int PRE_W      = 29,
   parameter bit ONESHOT_EN = 1'b1
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        tick_i,
   input  logic        wr_i,
   input  logic [31:0] wdata_i,
   output logic [31:0] ctrl_o,
   output logic        beat_o
);
   localparam logic [31:0] KEEP_MASK = ((32'd1 << PRE_W) - 32'd1)
                                      | (32'd1 << TMR_EN_BIT)
                                      | (32'd1 << TMR_PER_BIT);

   if (PRE_W < 1 || PRE_W > 30) begin : g_bad_prew
      $error("expwd_timer: PRE_W must be 1..30");
   end

   logic [31:0]      ctrl_q;
   logic [PRE_W-1:0] cnt_q, reload_v, wr_reload_v;
   logic             act_q, beat_q, keep_v;

   assign reload_v    = (ctrl_q[PRE_W-1:0] == '0) ? PRE_W'(1) : ctrl_q[PRE_W-1:0];
   assign wr_reload_v = (wdata_i[PRE_W-1:0] == '0) ? PRE_W'(1) : wdata_i[PRE_W-1:0];

   if (ONESHOT_EN) begin : g_oneshot
      assign keep_v = ctrl_q[TMR_PER_BIT];
   end else begin : g_always_periodic
      assign keep_v = 1'b1;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctrl_q <= '0;
         cnt_q  <= '0;
         act_q  <= 1'b0;
         beat_q <= 1'b0;
      end else begin
         beat_q <= 1'b0;
         if (wr_i) begin
            ctrl_q <= wdata_i & KEEP_MASK;
            act_q  <= wdata_i[TMR_EN_BIT];
            cnt_q  <= wr_reload_v;
         end else if (act_q && tick_i) begin
            if (cnt_q <= PRE_W'(1)) begin
               beat_q <= 1'b1;
               cnt_q  <= reload_v;
               act_q  <= keep_v;
            end else begin
               cnt_q <= cnt_q - PRE_W'(1);
            end
         end
      end
   end

   assign ctrl_o = ctrl_q;
   assign beat_o = beat_q;

   // R2: a beat only follows a tick seen while running
   p_beat_from_tick_r2: assert property (@(posedge clk) disable iff (!rst_n)
      beat_q |-> $past(tick_i));
   p_idle_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (!act_q && !wr_i) |=> !beat_q);
endmodule

// File: rtl/expwd_key.sv
`timescale 1ns/1ps
module expwd_key
   import expwd_pkg::*;
(
   input  logic        clk,
   input  logic        rst_n,
   input  logic        wr_i,
   input  logic        key_sel_i,
   input  logic [31:0] wdata_i,
   output logic        armed_o
);
   logic armed_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    armed_q <= 1'b0;
      else if (wr_i) armed_q <= key_sel_i && (wdata_i == HALT_KEY);
   end

   assign armed_o = armed_q;

   // R8: any non-key write drops the arming
   p_single_use_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_i && !key_sel_i) |=> !armed_q);
   // R7: correct key arms
   p_key_arms_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_i && key_sel_i && wdata_i == HALT_KEY) |=> armed_q);
endmodule

// File: rtl/expwd_core.sv
`timescale 1ns/1ps
module expwd_core
   import expwd_pkg::*;
#(
   parameter int PERIOD_W = 8,
   parameter int SEL_W    = 4,
   parameter int EXP_W    = 2,
   parameter int TMR_ID   = 5
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        beat_i,
   input  logic        cfg_wr_i,
   input  logic [31:0] wdata_i,
   input  logic        go_i,
   input  logic        halt_i,
   output logic [31:0] cfg_o,
   output logic [31:0] stat_o,
   output logic        irq_o,
   output logic        rst_req_o
);
   localparam logic [EXP_W-1:0] EXP_LAST = '1;

   if (PERIOD_W < 1 || PERIOD_W > 8) begin : g_bad_per
      $error("expwd_core: PERIOD_W must be 1..8");
   end
   if (SEL_W < 1 || SEL_W > 4 || TMR_ID >= (1 << SEL_W)) begin : g_bad_sel
      $error("expwd_core: SEL_W/TMR_ID out of range");
   end
   if (EXP_W < 1 || EXP_W > 2) begin : g_bad_exp
      $error("expwd_core: EXP_W must be 1..2");
   end

   logic [SEL_W-1:0]    sel_q;
   logic [PERIOD_W-1:0] period_q, count_q, reload_v;
   logic [EXP_W-1:0]    exp_q;
   logic                irq_en_q, rst_en_q, run_q, irq_q, req_q;
   logic                counted;
   logic                unused_wdata;

   assign unused_wdata = ^wdata_i;
   assign reload_v = (period_q == '0) ? PERIOD_W'(1) : period_q;
   assign counted  = beat_i && run_q && (sel_q == SEL_W'(TMR_ID));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sel_q    <= '0;
         period_q <= '0;
         irq_en_q <= 1'b0;
         rst_en_q <= 1'b0;
         count_q  <= '0;
         exp_q    <= '0;
         run_q    <= 1'b0;
         irq_q    <= 1'b0;
         req_q    <= 1'b0;
      end else begin
         irq_q <= 1'b0;
         if (cfg_wr_i) begin
            sel_q    <= wdata_i[CFG_SEL_LSB +: SEL_W];
            period_q <= wdata_i[CFG_PER_LSB +: PERIOD_W];
            irq_en_q <= wdata_i[CFG_IRQ_BIT];
            rst_en_q <= wdata_i[CFG_RST_BIT];
         end
         if (halt_i) begin
            run_q <= 1'b0;
         end else if (go_i) begin
            run_q   <= 1'b1;
            count_q <= reload_v;
            exp_q   <= '0;
         end else if (counted) begin
            if (count_q > PERIOD_W'(1)) begin
               count_q <= count_q - PERIOD_W'(1);
            end else if (exp_q != EXP_LAST) begin
               exp_q   <= exp_q + 1'b1;
               count_q <= reload_v;
               irq_q   <= irq_en_q;
            end else begin
               count_q <= '0;
               run_q   <= 1'b0;
               if (rst_en_q) req_q <= 1'b1;
            end
         end
      end
   end

   always_comb begin
      cfg_o = '0;
      cfg_o[CFG_SEL_LSB +: SEL_W]    = sel_q;
      cfg_o[CFG_PER_LSB +: PERIOD_W] = period_q;
      cfg_o[CFG_IRQ_BIT]             = irq_en_q;
      cfg_o[CFG_RST_BIT]             = rst_en_q;
      stat_o = '0;
      stat_o[ST_RUN_BIT]             = run_q;
      stat_o[ST_CNT_LSB +: PERIOD_W] = count_q;
      stat_o[ST_EXP_LSB +: EXP_W]    = exp_q;
   end

   assign irq_o     = irq_q;
   assign rst_req_o = req_q;

   p_req_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
      req_q |=> req_q);
   p_exp_rises_r5: assert property (@(posedge clk) disable iff (!rst_n)
      !go_i |=> (exp_q >= $past(exp_q)));
   p_irq_gated_r5: assert property (@(posedge clk) disable iff (!rst_n)
      irq_q |-> $past(irq_en_q));
   p_restart_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (go_i && !halt_i) |=> (run_q && exp_q == '0 && count_q != '0));
   p_restart_wins_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (go_i && !halt_i) |=> !irq_q);
endmodule

// File: rtl/expwd_unit.sv
`timescale 1ns/1ps
module expwd_unit
   import expwd_pkg::*;
#(
   parameter int ADDR_W     = 5,
   parameter int PRE_W      = 29,
   parameter bit ONESHOT_EN = 1'b1,
   parameter int PERIOD_W   = 8,
   parameter int SEL_W      = 4,
   parameter int EXP_W      = 2,
   parameter int TMR_ID     = 5
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              tick_1us_i,
   input  logic              bus_wr_i,
   input  logic [ADDR_W-1:0] bus_waddr_i,
   input  logic [31:0]       bus_wdata_i,
   input  logic [ADDR_W-1:0] bus_raddr_i,
   output logic [31:0]       bus_rdata_o,
   output logic              wdt_irq_o,
   output logic              sys_rst_req_o
);
   localparam int IDX_W = ADDR_W - 2;

   if (ADDR_W < 5) begin : g_bad_addr
      $error("expwd_unit: ADDR_W must be at least 5");
   end

   logic [IDX_W-1:0] widx, ridx;
   logic             wr_tmr, wr_cfg, wr_cmd, wr_key;
   logic             armed, beat, go, halt;
   logic [31:0]      tmr_ctrl, cfg_val, stat_val;
   logic             unused_addr;

   assign widx        = bus_waddr_i[ADDR_W-1:2];
   assign ridx        = bus_raddr_i[ADDR_W-1:2];
   assign unused_addr = ^{bus_waddr_i[1:0], bus_raddr_i[1:0]};

   assign wr_tmr = bus_wr_i && (widx == IDX_W'(REG_TMR));
   assign wr_cfg = bus_wr_i && (widx == IDX_W'(REG_CFG));
   assign wr_cmd = bus_wr_i && (widx == IDX_W'(REG_CMD));
   assign wr_key = bus_wr_i && (widx == IDX_W'(REG_KEY));

   assign go   = wr_cmd && bus_wdata_i[CMD_GO_BIT];
   assign halt = wr_cmd && bus_wdata_i[CMD_HALT_BIT] && armed;

   expwd_timer #(.PRE_W(PRE_W), .ONESHOT_EN(ONESHOT_EN)) u_timer (
      .clk     (clk),
      .rst_n   (rst_n),
      .tick_i  (tick_1us_i),
      .wr_i    (wr_tmr),
      .wdata_i (bus_wdata_i),
      .ctrl_o  (tmr_ctrl),
      .beat_o  (beat)
   );

   expwd_key u_key (
      .clk       (clk),
      .rst_n     (rst_n),
      .wr_i      (bus_wr_i),
      .key_sel_i (wr_key),
      .wdata_i   (bus_wdata_i),
      .armed_o   (armed)
   );

   expwd_core #(.PERIOD_W(PERIOD_W), .SEL_W(SEL_W), .EXP_W(EXP_W), .TMR_ID(TMR_ID)) u_core (
      .clk       (clk),
      .rst_n     (rst_n),
      .beat_i    (beat),
      .cfg_wr_i  (wr_cfg),
      .wdata_i   (bus_wdata_i),
      .go_i      (go),
      .halt_i    (halt),
      .cfg_o     (cfg_val),
      .stat_o    (stat_val),
      .irq_o     (wdt_irq_o),
      .rst_req_o (sys_rst_req_o)
   );

   always_comb begin
      bus_rdata_o = '0;
      if (ridx == IDX_W'(REG_TMR))       bus_rdata_o = tmr_ctrl;
      else if (ridx == IDX_W'(REG_CFG))  bus_rdata_o = cfg_val;
      else if (ridx == IDX_W'(REG_STAT)) bus_rdata_o = stat_val;
   end

   // R7: an unarmed halt leaves a running watchdog running
   p_halt_needs_key_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_cmd && bus_wdata_i[CMD_HALT_BIT] && !bus_wdata_i[CMD_GO_BIT] && !armed
       && stat_val[ST_RUN_BIT] && !beat) |=> stat_val[ST_RUN_BIT]);
endmodule

// File: tb/tb_expwd_unit.sv
`timescale 1ns/1ps
module tb_expwd_unit;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        tick = 1'b0;
   logic        wr = 1'b0;
   logic [4:0]  waddr = '0;
   logic [31:0] wdata = '0;
   logic [4:0]  raddr = '0;
   logic [31:0] rdata;
   logic        irq, sysrst;

   int total = 0;
   int bad = 0;
   int irq_seen = 0;
   bit done = 0;

   always #10 clk = ~clk;

   expwd_unit dut (
      .clk(clk), .rst_n(rst_n), .tick_1us_i(tick),
      .bus_wr_i(wr), .bus_waddr_i(waddr), .bus_wdata_i(wdata),
      .bus_raddr_i(raddr), .bus_rdata_o(rdata),
      .wdt_irq_o(irq), .sys_rst_req_o(sysrst)
   );

   always @(negedge clk) if (rst_n && irq) irq_seen++;

   function automatic logic [31:0] cfgw(int sel, int per, bit ie, bit re);
      return 32'(sel) | (32'(per) << 4) | (32'(ie) << 12) | (32'(re) << 15);
   endfunction

   task automatic chk(string what, logic [31:0] got, logic [31:0] exp);
      total++;
      if (got !== exp) begin
         bad++;
         $display("FAIL %s: got %h expected %h", what, got, exp);
      end
   endtask

   task automatic bwr(logic [4:0] a, logic [31:0] d);
      @(negedge clk);
      wr = 1'b1; waddr = a; wdata = d;
      @(negedge clk);
      wr = 1'b0;
   endtask

   task automatic brd(logic [4:0] a, output logic [31:0] d);
      raddr = a;
      #1;
      d = rdata;
   endtask

   task automatic ticks(int n);
      for (int i = 0; i < n; i++) begin
         @(negedge clk); tick = 1'b1;
         @(negedge clk); tick = 1'b0;
         @(negedge clk);
         @(negedge clk);
      end
   endtask

   task automatic do_reset();
      @(negedge clk); rst_n = 1'b0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
   endtask

   task automatic stat(output logic run, output int cnt, output int ex);
      logic [31:0] v;
      brd(5'h08, v);
      run = v[0]; cnt = int'(v[11:4]); ex = int'(v[13:12]);
   endtask

   task automatic t_reset();
      logic [31:0] v;
      brd(5'h00, v); chk("R1 timer ctrl", v, 0);
      brd(5'h04, v); chk("R1 setup", v, 0);
      brd(5'h08, v); chk("R1 status", v, 0);
      chk("R1 reset req", 32'(sysrst), 0);
      chk("R1 irq count", irq_seen, 0);
   endtask

   task automatic t_timer();
      logic run; int c, e; logic [31:0] v;
      bwr(5'h04, cfgw(5, 20, 0, 0));
      bwr(5'h00, 32'hC000_0003);
      bwr(5'h0C, 32'h1);
      stat(run, c, e);
      chk("R4 running after go", 32'(run), 1);
      chk("R4 count loaded", c, 20);
      ticks(9);
      stat(run, c, e); chk("R2 periodic reload 3, 9 ticks", c, 17);
      bwr(5'h00, 32'h0);
      ticks(6);
      stat(run, c, e); chk("R2 stopped timer", c, 17);
      bwr(5'h00, 32'h8000_0002);
      brd(5'h00, v); chk("R2 ctrl readback", v, 32'h8000_0002);
      ticks(8);
      stat(run, c, e); chk("R2 one-shot single beat", c, 16);
   endtask

   task automatic t_select();
      logic run; int c, e; logic [31:0] v;
      bwr(5'h00, 32'hC000_0001);
      bwr(5'h04, cfgw(5, 8'hAB, 1, 1));
      brd(5'h04, v); chk("R3 setup readback", v, cfgw(5, 8'hAB, 1, 1));
      bwr(5'h04, cfgw(4, 10, 0, 0));
      bwr(5'h0C, 32'h1);
      ticks(3);
      stat(run, c, e); chk("R3 other timer select ignored", c, 10);
      bwr(5'h04, cfgw(5, 0, 0, 0));
      bwr(5'h0C, 32'h1);
      stat(run, c, e); chk("R3 period 0 loads 1", c, 1);
      ticks(1);
      stat(run, c, e);
      chk("R3 period 0 strike", e, 1);
      chk("R3 period 0 reload", c, 1);
   endtask

   task automatic t_count();
      logic run; int c, e; int i0;
      bwr(5'h04, cfgw(5, 3, 1, 0));
      bwr(5'h0C, 32'h1);
      i0 = irq_seen;
      ticks(2);
      stat(run, c, e); chk("R5 countdown", c, 1);
      ticks(1);
      stat(run, c, e);
      chk("R5 strike count", e, 1);
      chk("R5 reload on strike", c, 3);
      chk("R5 irq pulse once", irq_seen - i0, 1);
      ticks(2);
      bwr(5'h0C, 32'h1);
      stat(run, c, e);
      chk("R4 keep-alive count", c, 3);
      chk("R4 keep-alive clears strikes", e, 0);
   endtask

   task automatic t_collide();
      logic run; int c, e; int i0;
      ticks(2);
      stat(run, c, e); chk("R9 setup count 1", c, 1);
      i0 = irq_seen;
      @(negedge clk); tick = 1'b1;
      @(negedge clk); tick = 1'b0; wr = 1'b1; waddr = 5'h0C; wdata = 32'h1;
      @(negedge clk); wr = 1'b0;
      @(negedge clk); @(negedge clk);
      stat(run, c, e);
      chk("R9 restart wins count", c, 3);
      chk("R9 restart wins strikes", e, 0);
      chk("R9 no irq", irq_seen - i0, 0);
   endtask

   task automatic t_fourth();
      logic run; int c, e; int i0;
      bwr(5'h04, cfgw(5, 2, 1, 0));
      bwr(5'h0C, 32'h1);
      i0 = irq_seen;
      ticks(8);
      stat(run, c, e);
      chk("R6 disabled reset: strikes", e, 3);
      chk("R6 stopped", 32'(run), 0);
      chk("R6 count zero", c, 0);
      chk("R6 no request when disabled", 32'(sysrst), 0);
      chk("R6 three irqs", irq_seen - i0, 3);
      bwr(5'h04, cfgw(5, 2, 1, 1));
      bwr(5'h0C, 32'h1);
      ticks(7);
      chk("R6 no request before fourth", 32'(sysrst), 0);
      ticks(1);
      chk("R6 request on fourth", 32'(sysrst), 1);
      bwr(5'h0C, 32'h1);
      ticks(2);
      chk("R6 request sticky", 32'(sysrst), 1);
      do_reset();
      chk("R6 request cleared by reset", 32'(sysrst), 0);
   endtask

   task automatic t_key();
      logic run; int c, e;
      bwr(5'h00, 32'hC000_0001);
      bwr(5'h04, cfgw(5, 50, 0, 0));
      bwr(5'h0C, 32'h1);
      bwr(5'h0C, 32'h2);
      stat(run, c, e); chk("R7 halt without key ignored", 32'(run), 1);
      bwr(5'h10, 32'h0000_C45A);
      bwr(5'h0C, 32'h2);
      stat(run, c, e); chk("R7 halt with key", 32'(run), 0);
      ticks(3);
      stat(run, c, e); chk("R7 halted holds count", c, 50);
      bwr(5'h0C, 32'h1);
      bwr(5'h10, 32'h0000_C45A);
      bwr(5'h04, cfgw(5, 50, 0, 0));
      bwr(5'h0C, 32'h2);
      stat(run, c, e); chk("R8 other write drops key", 32'(run), 1);
      bwr(5'h10, 32'h0000_C45B);
      bwr(5'h0C, 32'h2);
      stat(run, c, e); chk("R8 wrong key", 32'(run), 1);
      bwr(5'h10, 32'h0000_C45A);
      bwr(5'h0C, 32'h2);
      bwr(5'h0C, 32'h1);
      bwr(5'h0C, 32'h2);
      stat(run, c, e); chk("R8 key used once", 32'(run), 1);
   endtask

   initial begin
      do_reset();
      t_reset();
      t_timer();
      t_select();
      t_count();
      t_collide();
      t_fourth();
      t_key();
      done = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         total++; bad++;
         $display("FAIL watchdog: got timeout expected completion");
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end
endmodule